// File: doc/BRIEF.md
# Passcode-Locked Interrupt Register Bank

This block is a small word-wide register slice that collects single-cycle event pulses from neighbouring logic into a sticky status word and raises one level interrupt whenever an unmasked status bit is set. Software clears status bits by writing ones to them. It cannot write the mask directly: one register clears mask bits and another sets them.

A key register guards the bank. After reset the bank is locked, and every write to any other offset is discarded. Writing the exact unlock word opens the bank. Writing any other value to the key register closes it again. Event pulses keep setting status bits whether the bank is locked or not.

The bus side is a plain port with a byte address, 32-bit write data, a write strobe and combinational read data. Accesses are whole words only. The interrupt output is registered.

Top module: `irq_lockbank`

## Requirements
- R1: After reset the key register (offset 0x00) reads 1. Status (0x04) reads 0, mask (0x08) reads 0x80007FFF, and the interrupt output is low.
- R2: A write of exactly 0x0000DF0D to the key register makes it read 0 (unlocked). A write of any other 32-bit value makes it read 1 (locked).
- R3: While the key register holds 1, writes to offsets 0x04, 0x08, 0x0C and 0x10 change no state.
- R4: A one-cycle pulse on event input bit i sets status bit i when i is 0..14 or 31, whether the bank is locked or not. Status bits 15..30 always read 0.
- R5: An unlocked write to the status offset clears exactly the status bits written as 1 and leaves the others unchanged.
- R6: The mask offset is read-only. Writes to it leave the mask unchanged.
- R7: An unlocked write to the unmask offset (0x0C) clears the written mask bits. An unlocked write to the set-mask offset (0x10) sets the written mask bits, limited to bits 0..14 and 31. Both offsets read 0.
- R8: The interrupt output equals the OR of (status AND NOT mask) as it stood one clock earlier. It rises or falls one cycle after an event, clear, unmask or set-mask changes that term.
- R9: When an event pulse and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R10: Reads of unmapped or misaligned offsets return 0. Writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the word access |
| bus_wdata | input | DATA_W | Write data |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |
| evt_pulse | input | DATA_W | Single-cycle event pulses, one per status bit |
| irq_o | output | 1 | Level interrupt, registered |

## Verification
The case that needs care is an event pulse and a software write landing on the same cycle. The event can fall together with a write-one-to-clear on the same status bit, or on a neighbouring bit that is being cleared. The bench drives the pulse and the write on the same edge and expects the pulsed bit to stay set and the other written bit to clear. It also lines up a mask change and a status change with the registered interrupt. It samples the interrupt both before and after the following edge, to confirm the one-clock lag in both directions.

// File: rtl/irq_lockbank_pkg.sv
package irq_lockbank_pkg;
   // byte stride between adjacent word registers
   localparam int unsigned WORD_BYTES = 4;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_KEY,
      SEL_STAT,
      SEL_MASK,
      SEL_UNMASK,
      SEL_SETMASK
   } lb_sel_e;
endpackage

// File: rtl/irq_lockbank_lock.sv
module irq_lockbank_lock #(
   parameter int unsigned       DATA_W   = 32,
   parameter logic [DATA_W-1:0] PASSCODE = 32'h0000_DF0D
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              key_we,
   input  logic [DATA_W-1:0] key_wdata,
   output logic              locked_o
);
   logic locked_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      locked_q <= 1'b1;
      else if (key_we) locked_q <= (key_wdata != PASSCODE);
   end

   assign locked_o = locked_q;

   assert_unlock_on_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (key_we && key_wdata == PASSCODE) |=> !locked_o);
   assert_relock_on_other_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (key_we && key_wdata != PASSCODE) |=> locked_o);
   assert_key_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !key_we |=> $stable(locked_o));
endmodule

// File: rtl/irq_lockbank_status.sv
module irq_lockbank_status #(
   parameter int unsigned       DATA_W    = 32,
   parameter logic [DATA_W-1:0] SRC_VALID = 32'h8000_7FFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_en,
   input  logic [DATA_W-1:0] clr_data,
   input  logic [DATA_W-1:0] evt,
   output logic [DATA_W-1:0] status_o
);
   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (SRC_VALID[i]) begin : g_live
         logic bit_q;
         // an event in the same cycle overrides the clear
         always_ff @(posedge clk) begin
            if (!rst_n) bit_q <= 1'b0;
            else        bit_q <= evt[i] | (bit_q & ~(clr_en & clr_data[i]));
         end
         assign status_o[i] = bit_q;
      end else begin : g_rsvd
         assign status_o[i] = 1'b0;
      end
   end

   assert_w1c_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      clr_en |=> ((status_o & $past(clr_data & ~evt)) == '0));
   assert_event_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (|(evt & SRC_VALID)) |=>
         ((status_o & $past(evt & SRC_VALID)) == $past(evt & SRC_VALID)));
endmodule

// File: rtl/irq_lockbank_mask.sv
module irq_lockbank_mask #(
   parameter int unsigned       DATA_W    = 32,
   parameter logic [DATA_W-1:0] SRC_VALID = 32'h8000_7FFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              unmask_en,
   input  logic              setmask_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] mask_o
);
   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (SRC_VALID[i]) begin : g_live
         logic bit_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                        bit_q <= 1'b1;
            else if (unmask_en  && wdata[i])   bit_q <= 1'b0;
            else if (setmask_en && wdata[i])   bit_q <= 1'b1;
         end
         assign mask_o[i] = bit_q;
      end else begin : g_rsvd
         assign mask_o[i] = 1'b0;
      end
   end

   assert_unmask_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      unmask_en |=> ((mask_o & $past(wdata)) == '0));
   assert_setmask_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
      setmask_en |=> ((mask_o & $past(wdata & SRC_VALID)) == $past(wdata & SRC_VALID)));
endmodule

// File: rtl/irq_lockbank.sv
module irq_lockbank
   import irq_lockbank_pkg::*;
#(
   parameter int unsigned       DATA_W      = 32,
   parameter int unsigned       ADDR_W      = 8,
   parameter logic [DATA_W-1:0] PASSCODE    = 32'h0000_DF0D,
   parameter logic [DATA_W-1:0] SRC_VALID   = 32'h8000_7FFF,
   parameter int unsigned       OFF_KEY     = 0,
   parameter int unsigned       OFF_STAT    = 4,
   parameter int unsigned       OFF_MASK    = 8,
   parameter int unsigned       OFF_UNMASK  = 12,
   parameter int unsigned       OFF_SETMASK = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_wr,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [DATA_W-1:0] evt_pulse,
   output logic              irq_o
);
   localparam int unsigned ADDR_SPAN = 1 << ADDR_W;

   // elaboration-time parameter checks
   if (DATA_W < 2) begin : g_chk_width
      $error("irq_lockbank: DATA_W must be at least 2");
   end
   if (OFF_KEY >= ADDR_SPAN || OFF_STAT >= ADDR_SPAN || OFF_MASK >= ADDR_SPAN ||
       OFF_UNMASK >= ADDR_SPAN || OFF_SETMASK >= ADDR_SPAN) begin : g_chk_span
      $error("irq_lockbank: register offset beyond ADDR_W");
   end
   if ((OFF_KEY % WORD_BYTES) != 0 || (OFF_STAT % WORD_BYTES) != 0 ||
       (OFF_MASK % WORD_BYTES) != 0 || (OFF_UNMASK % WORD_BYTES) != 0 ||
       (OFF_SETMASK % WORD_BYTES) != 0) begin : g_chk_align
      $error("irq_lockbank: register offsets must be word aligned");
   end

   lb_sel_e           sel;
   logic              locked;
   logic              wr_open;
   logic [DATA_W-1:0] status;
   logic [DATA_W-1:0] mask;
   logic              irq_q;

   always_comb begin
      sel = SEL_NONE;
      if      (bus_addr == ADDR_W'(OFF_KEY))     sel = SEL_KEY;
      else if (bus_addr == ADDR_W'(OFF_STAT))    sel = SEL_STAT;
      else if (bus_addr == ADDR_W'(OFF_MASK))    sel = SEL_MASK;
      else if (bus_addr == ADDR_W'(OFF_UNMASK))  sel = SEL_UNMASK;
      else if (bus_addr == ADDR_W'(OFF_SETMASK)) sel = SEL_SETMASK;
   end

   assign wr_open = bus_wr && !locked;

   irq_lockbank_lock #(.DATA_W(DATA_W), .PASSCODE(PASSCODE)) u_lock (
      .clk       (clk),
      .rst_n     (rst_n),
      .key_we    (bus_wr && sel == SEL_KEY),
      .key_wdata (bus_wdata),
      .locked_o  (locked)
   );

   irq_lockbank_status #(.DATA_W(DATA_W), .SRC_VALID(SRC_VALID)) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_en   (wr_open && sel == SEL_STAT),
      .clr_data (bus_wdata),
      .evt      (evt_pulse),
      .status_o (status)
   );

   irq_lockbank_mask #(.DATA_W(DATA_W), .SRC_VALID(SRC_VALID)) u_mask (
      .clk        (clk),
      .rst_n      (rst_n),
      .unmask_en  (wr_open && sel == SEL_UNMASK),
      .setmask_en (wr_open && sel == SEL_SETMASK),
      .wdata      (bus_wdata),
      .mask_o     (mask)
   );

   always_comb begin
      unique case (sel)
         SEL_KEY:  bus_rdata = {{(DATA_W-1){1'b0}}, locked};
         SEL_STAT: bus_rdata = status;
         SEL_MASK: bus_rdata = mask;
         default:  bus_rdata = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |(status & ~mask);
   end
   assign irq_o = irq_q;

   assert_locked_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && bus_wr && sel != SEL_KEY && !(|(evt_pulse & SRC_VALID)))
         |=> ($stable(status) && $stable(mask)));
   assert_irq_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (|(status & ~mask)) |=> irq_o);
   assert_irq_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(status & ~mask)) |=> !irq_o);
   assert_unmapped_inert_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && sel == SEL_NONE && !(|(evt_pulse & SRC_VALID)))
         |=> ($stable(status) && $stable(mask) && $stable(locked)));
endmodule

// File: tb/irq_lockbank_bench.sv
module irq_lockbank_bench;
   localparam int          CLK_PERIOD = 10;
   localparam logic [31:0] PASS  = 32'h0000_DF0D;
   localparam logic [31:0] VALID = 32'h8000_7FFF;
   localparam logic [7:0]  A_KEY = 8'h00, A_STAT = 8'h04, A_MASK = 8'h08,
                           A_UN = 8'h0C, A_SET = 8'h10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_rdata;
   logic [31:0] evt = '0;
   logic        irq;
   int          n_cmp = 0;
   int          n_bad = 0;
   bit          done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_lockbank u_irq_lockbank (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_wr(bus_wr), .bus_rdata(bus_rdata), .evt_pulse(evt), .irq_o(irq)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic pulse(input logic [31:0] v);
      @(negedge clk);
      evt = v;
      @(negedge clk);
      evt = '0;
   endtask

   task automatic chk_reg(input string tag, input logic [7:0] a, input logic [31:0] exp);
      bus_addr = a;
      #1;
      check(tag, bus_rdata, exp);
   endtask

   task automatic chk_irq(input string tag, input logic exp);
      check(tag, {31'b0, irq}, {31'b0, exp});
   endtask

   task automatic summary;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk_reg("R1 key", A_KEY, 32'h1);
      chk_reg("R1 status", A_STAT, 32'h0);
      chk_reg("R1 mask", A_MASK, VALID);
      chk_irq("R1 irq", 1'b0);

      // R3 locked writes are dropped; events still land (R4)
      wr(A_UN, 32'hFFFF_FFFF);
      chk_reg("R3 unmask while locked", A_MASK, VALID);
      pulse(32'h1);
      chk_reg("R4 event while locked", A_STAT, 32'h1);
      wr(A_STAT, 32'h1);
      chk_reg("R3 clear while locked", A_STAT, 32'h1);

      // R2 passcode sweep: every single-bit neighbour of the passcode relocks
      wr(A_KEY, 32'h1234_DF0D);
      chk_reg("R2 upper bits set", A_KEY, 32'h1);
      for (int k = 0; k < 32; k++) begin
         wr(A_KEY, PASS ^ (32'h1 << k));
         chk_reg("R2 near miss", A_KEY, 32'h1);
         wr(A_KEY, PASS);
         chk_reg("R2 exact", A_KEY, 32'h0);
      end

      wr(A_STAT, 32'hFFFF_FFFF);
      chk_reg("R5 clear all", A_STAT, 32'h0);

      // R4/R5 per-bit sweep, all masked so irq stays low
      for (int i = 0; i < 32; i++) begin
         logic [31:0] b;
         b = 32'h1 << i;
         pulse(b);
         chk_reg("R4 set bit", A_STAT, b & VALID);
         @(negedge clk);
         chk_irq("R8 masked", 1'b0);
         wr(A_STAT, ~b);
         chk_reg("R5 zeros ignored", A_STAT, b & VALID);
         wr(A_STAT, b);
         chk_reg("R5 one clears", A_STAT, 32'h0);
      end

      pulse(32'hF);
      wr(A_STAT, 32'h5);
      chk_reg("R5 partial", A_STAT, 32'hA);
      wr(A_STAT, 32'hF);

      // R6 mask read-only
      wr(A_MASK, 32'h0);
      chk_reg("R6 mask write", A_MASK, VALID);

      // R7 reserved bits and read-as-zero
      wr(A_UN, 32'hFFFF_FFFF);
      chk_reg("R7 unmask all", A_MASK, 32'h0);
      chk_reg("R7 unmask reads 0", A_UN, 32'h0);
      chk_reg("R7 setmask reads 0", A_SET, 32'h0);
      wr(A_SET, 32'hFFFF_FFFF);
      chk_reg("R7 setmask all", A_MASK, VALID);
      wr(A_UN, 32'h0000_0012);
      chk_reg("R7 unmask some", A_MASK, VALID & ~32'h12);
      wr(A_SET, 32'h0000_0002);
      chk_reg("R7 setmask some", A_MASK, VALID & ~32'h10);
      wr(A_SET, 32'h10);

      // R8 interrupt lag sweep over valid bits
      for (int i = 0; i < 32; i++) begin
         if (VALID[i]) begin
            logic [31:0] b;
            b = 32'h1 << i;
            pulse(b);
            chk_irq("R8 masked pending", 1'b0);
            wr(A_UN, b);
            chk_irq("R8 before lag edge", 1'b0);
            @(negedge clk);
            chk_irq("R8 rise after unmask", 1'b1);
            wr(A_STAT, b);
            chk_irq("R8 still high", 1'b1);
            @(negedge clk);
            chk_irq("R8 fall after clear", 1'b0);
            wr(A_SET, b);
         end
      end
      // event into an unmasked bit, then set-mask drops it
      wr(A_UN, 32'h8);
      pulse(32'h8);
      chk_irq("R8 event lag", 1'b0);
      @(negedge clk);
      chk_irq("R8 event rise", 1'b1);
      wr(A_SET, 32'h8);
      chk_irq("R8 mask lag", 1'b1);
      @(negedge clk);
      chk_irq("R8 mask fall", 1'b0);
      wr(A_STAT, 32'h8);

      // R9 event and clear on the same cycle
      pulse(32'h6);
      @(negedge clk);
      evt = 32'h4; bus_addr = A_STAT; bus_wdata = 32'h6; bus_wr = 1'b1;
      @(negedge clk);
      evt = '0; bus_wr = 1'b0; bus_wdata = '0;
      chk_reg("R9 event beats clear", A_STAT, 32'h4);
      wr(A_STAT, 32'h4);

      // R10 unmapped offsets
      pulse(32'h1);
      chk_reg("R10 read 0x14", 8'h14, 32'h0);
      chk_reg("R10 read 0x06", 8'h06, 32'h0);
      chk_reg("R10 read 0xFC", 8'hFC, 32'h0);
      wr(8'h14, 32'hFFFF_FFFF);
      wr(8'h05, 32'hFFFF_FFFF);
      chk_reg("R10 status kept", A_STAT, 32'h1);
      chk_reg("R10 mask kept", A_MASK, VALID);
      chk_reg("R10 key kept", A_KEY, 32'h0);

      // R2 relock with zero, then R3 again
      wr(A_KEY, 32'h0);
      chk_reg("R2 relock", A_KEY, 32'h1);
      wr(A_UN, 32'h1);
      chk_reg("R3 relocked unmask", A_MASK, VALID);
      @(negedge clk);
      chk_irq("R3 irq stays low", 1'b0);

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         summary();
         $finish;
      end
   end
endmodule